// File: doc/BRIEF.md
# Parallel ATA Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA channel pair. Four 32-bit timing words are held on chip, one per device per channel. The word for a device is picked by device number plus twice the channel number. A host-side requester asks for one read or write cycle at a time. With each request it says whether the cycle moves data (PIO or multiword DMA) or reaches a task-file register, and whether this is the first cycle of a sequence.

When a request is accepted, the block latches the timing fields that belong to the cycle type. It then runs three phases, counted in controller clocks. First comes an optional setup phase, used on first cycles only. Next the selected strobe is driven low for the active phase. A recovery phase with the strobe high follows. A one-clock done pulse closes the cycle. The four top bits of each word are mode flags; they are reported as outputs and have no effect on timing.

Top module: `pata_strobe_timer`

## Requirements
- R1: For a data cycle (taskfile flag 0), the selected strobe is low for exactly word[8:4]+1 clocks.
- R2: For a data cycle, the recovery phase (strobe high, before done) lasts word[3:0]+1 clocks.
- R3: For a task-file cycle (taskfile flag 1), the strobe is low for word[17:13]+1 clocks and recovery lasts word[12:9]+1 clocks.
- R4: A first data cycle waits word[24:22] clocks, with no plus one, between acceptance and the strobe going low. A zero field inserts no wait. A cycle that is not a first cycle never waits.
- R5: A first task-file cycle waits word[27:25] clocks before the strobe goes low.
- R6: The word used is the one at index dev + 2*chan. Writing one index leaves the timing of the other three unchanged.
- R7: Reads lower only rd_n and writes lower only wr_n. The other strobe stays high, the two strobes are never low together, and both are high whenever the block is idle.
- R8: done is high for exactly one clock, in the clock right after the last recovery clock. req_ready is low from acceptance until that clock and high again in it.
- R9: A word written while a cycle is running leaves that cycle's timing unchanged and applies from the next accepted request.
- R10: mode_flags equals bits 31:28 of the word addressed by req_chan and req_dev. These bits do not change strobe timing.
- R11: A synchronous active-high reset leaves both strobes high, done low and req_ready high, and clears all four words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_chan | input | 1 | Channel of the word being written |
| cfg_dev | input | 1 | Device of the word being written |
| cfg_wdata | input | 32 | Timing word write data |
| req_valid | input | 1 | Cycle request valid |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_chan | input | 1 | Channel of the requested cycle |
| req_dev | input | 1 | Device of the requested cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_taskfile | input | 1 | 1 = task-file register cycle, 0 = data cycle |
| req_first | input | 1 | 1 = first cycle of a sequence (setup applies) |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse when the cycle completes |
| mode_flags | output | 4 | Bits 31:28 of the addressed word |

## Verification
The bench aims at the boundaries of each field. These include a zero setup field, a maximum setup of 7 on both cycle types, the largest active and recovery counts, and a first flag that is clear while the setup fields are full. A design that added one to the setup count, or applied setup to cycles that are not first cycles, would show extra high clocks before the strobe falls. A design that read the data fields for a task-file cycle, or the reverse, would show the wrong low and high lengths. A timing word is also rewritten in the middle of a cycle, so a design that reads the live word instead of the latched fields would stretch or shorten the cycle already under way.

// File: rtl/pata_strobe_pkg.sv
package pata_strobe_pkg;
   localparam int WORD_W  = 32;
   localparam int SET_W   = 3;
   localparam int ACT_W   = 5;
   localparam int REC_W   = 4;
   localparam int CNT_W   = ACT_W;
   localparam int FLAG_W  = 4;

   // field positions that the sequencer depends on
   localparam int D_REC_LSB  = 0;
   localparam int D_ACT_LSB  = 4;
   localparam int T_REC_LSB  = 9;
   localparam int T_ACT_LSB  = 13;
   localparam int D_SET_LSB  = 22;
   localparam int T_SET_LSB  = 25;
   localparam int FLAG_LSB   = 28;

   typedef struct packed {
      logic [SET_W-1:0] setup;
      logic [ACT_W-1:0] active;
      logic [REC_W-1:0] recover;
   } strobe_time_t;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } phase_e;
endpackage

// File: rtl/pata_cfg_bank.sv
module pata_cfg_bank
   import pata_strobe_pkg::*;
#(
   parameter int NUM_WORDS = 4,
   parameter int IDX_W     = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [WORD_W-1:0] rword
);
   logic [WORD_W-1:0] words [NUM_WORDS];

   for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)
            words[gi] <= '0;
         else if (we && (widx == IDX_W'(gi)))
            words[gi] <= wdata;
      end
   end

   always_comb begin
      rword = '0;
      for (int i = 0; i < NUM_WORDS; i++)
         if (ridx == IDX_W'(i)) rword = words[i];
   end
endmodule

// File: rtl/pata_field_sel.sv
module pata_field_sel
   import pata_strobe_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic              taskfile,
   input  logic              first,
   output strobe_time_t      tsel
);
   logic [SET_W-1:0] set_fld;
   logic [3:0]       unused_bits;

   assign unused_bits = word[21:18];

   always_comb begin
      if (taskfile) begin
         set_fld      = word[T_SET_LSB +: SET_W];
         tsel.active  = word[T_ACT_LSB +: ACT_W];
         tsel.recover = word[T_REC_LSB +: REC_W];
      end else begin
         set_fld      = word[D_SET_LSB +: SET_W];
         tsel.active  = word[D_ACT_LSB +: ACT_W];
         tsel.recover = word[D_REC_LSB +: REC_W];
      end
      tsel.setup = first ? set_fld : '0;
   end
endmodule

// File: rtl/pata_phase_seq.sv
module pata_phase_seq
   import pata_strobe_pkg::*;
(
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         wr_in,
   input  strobe_time_t tin,
   output logic         ready,
   output logic         rd_n,
   output logic         wr_n,
   output logic         done
);
   phase_e             phase;
   logic [CNT_W-1:0]   cnt;
   logic [REC_W-1:0]   rec_q;
   logic [ACT_W-1:0]   act_q;
   logic               wr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         rec_q <= '0;
         act_q <= '0;
         wr_q  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start) begin
               wr_q  <= wr_in;
               act_q <= tin.active;
               rec_q <= tin.recover;
               if (tin.setup != '0) begin
                  phase <= PH_SETUP;
                  cnt   <= CNT_W'(tin.setup) - CNT_W'(1);
               end else begin
                  phase <= PH_ACTIVE;
                  cnt   <= CNT_W'(tin.active);
               end
            end
            PH_SETUP: if (cnt == '0) begin
               phase <= PH_ACTIVE;
               cnt   <= CNT_W'(act_q);
            end else cnt <= cnt - CNT_W'(1);
            PH_ACTIVE: if (cnt == '0) begin
               phase <= PH_RECOV;
               cnt   <= CNT_W'(rec_q);
            end else cnt <= cnt - CNT_W'(1);
            PH_RECOV: if (cnt == '0) begin
               phase <= PH_IDLE;
               done  <= 1'b1;
            end else cnt <= cnt - CNT_W'(1);
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign ready = (phase == PH_IDLE);
   assign rd_n  = !((phase == PH_ACTIVE) && !wr_q);
   assign wr_n  = !((phase == PH_ACTIVE) &&  wr_q);
endmodule

// File: rtl/pata_strobe_timer.sv
module pata_strobe_timer
   import pata_strobe_pkg::*;
#(
   parameter int NUM_CHAN = 2,
   parameter int NUM_DEV  = 2,
   parameter int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
   parameter int DEV_W    = (NUM_DEV  > 1) ? $clog2(NUM_DEV)  : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [CHAN_W-1:0] cfg_chan,
   input  logic [DEV_W-1:0]  cfg_dev,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CHAN_W-1:0] req_chan,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic              req_write,
   input  logic              req_taskfile,
   input  logic              req_first,
   output logic              rd_n,
   output logic              wr_n,
   output logic              done,
   output logic [FLAG_W-1:0] mode_flags
);
   localparam int NUM_WORDS = NUM_CHAN * NUM_DEV;
   localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   if (NUM_CHAN < 1 || NUM_DEV < 1) begin : g_bad_count
      $error("pata_strobe_timer: channel and device counts must be at least 1");
   end
   if (NUM_WORDS > 64) begin : g_bad_size
      $error("pata_strobe_timer: too many timing words");
   end

   logic [IDX_W-1:0]  widx, ridx;
   logic [WORD_W-1:0] rword;
   strobe_time_t      tsel;
   logic              accept;

   assign widx   = IDX_W'(cfg_dev) + IDX_W'(NUM_DEV) * IDX_W'(cfg_chan);
   assign ridx   = IDX_W'(req_dev) + IDX_W'(NUM_DEV) * IDX_W'(req_chan);
   assign accept = req_valid && req_ready;

   pata_cfg_bank #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (cfg_we),
      .widx  (widx),
      .wdata (cfg_wdata),
      .ridx  (ridx),
      .rword (rword)
   );

   pata_field_sel u_sel (
      .word     (rword),
      .taskfile (req_taskfile),
      .first    (req_first),
      .tsel     (tsel)
   );

   pata_phase_seq u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (accept),
      .wr_in (req_write),
      .tin   (tsel),
      .ready (req_ready),
      .rd_n  (rd_n),
      .wr_n  (wr_n),
      .done  (done)
   );

   assign mode_flags = rword[FLAG_LSB +: FLAG_W];
endmodule

// File: rtl/pata_strobe_timer_chk.sv
module pata_strobe_timer_chk (
   input logic clk,
   input logic rst,
   input logic req_valid,
   input logic req_ready,
   input logic rd_n,
   input logic wr_n,
   input logic done
);
   AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n)); // R7

   AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (rd_n && wr_n)); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R8

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready); // R8

   AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
      done |-> req_ready); // R8

   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(rst) |-> (rd_n && wr_n && !done && req_ready)); // R11
endmodule

bind pata_strobe_timer pata_strobe_timer_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .done      (done)
);

// File: tb/pata_strobe_timer_tb.sv
module pata_strobe_timer_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic        cfg_chan = 1'b0, cfg_dev = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0, req_ready;
   logic        req_chan = 1'b0, req_dev = 1'b0;
   logic        req_write = 1'b0, req_taskfile = 1'b0, req_first = 1'b0;
   logic        rd_n, wr_n, done;
   logic [3:0]  mode_flags;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pata_strobe_timer u_dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_dev(cfg_dev),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_chan(req_chan), .req_dev(req_dev), .req_write(req_write),
      .req_taskfile(req_taskfile), .req_first(req_first), .rd_n(rd_n), .wr_n(wr_n),
      .done(done), .mode_flags(mode_flags)
   );

   // vector: [39]=chan [38]=dev [37]=write [36]=taskfile [35]=first [31:0]=word
   localparam logic [39:0] VEC [8] = '{
      {1'b0,1'b0,1'b0,1'b0,1'b1,3'b0,32'hC0C8A731},
      {1'b0,1'b1,1'b1,1'b0,1'b0,3'b0,32'h90CB8542},
      {1'b1,1'b0,1'b0,1'b1,1'b1,3'b0,32'h1E4D3A95},
      {1'b1,1'b1,1'b1,1'b1,1'b1,3'b0,32'h0120A7A7},
      {1'b0,1'b0,1'b1,1'b0,1'b1,3'b0,32'hA0200063},
      {1'b1,1'b1,1'b0,1'b1,1'b0,3'b0,32'hFFFFFFFF},
      {1'b0,1'b1,1'b0,1'b0,1'b1,3'b0,32'h01C0001F},
      {1'b1,1'b0,1'b1,1'b1,1'b1,3'b0,32'h0E000000}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_word(input logic ch, input logic dv, input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_chan = ch; cfg_dev = dv; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic void expect_time(input logic [31:0] w, input logic tf, input logic fst,
                                       output int s, output int a, output int r);
      if (tf) begin
         s = fst ? int'(w[27:25]) : 0;
         a = int'(w[17:13]) + 1;
         r = int'(w[12:9]) + 1;
      end else begin
         s = fst ? int'(w[24:22]) : 0;
         a = int'(w[8:4]) + 1;
         r = int'(w[3:0]) + 1;
      end
   endfunction

   // Issue one cycle, measure setup/active/recovery at the ports.
   task automatic run_cycle(input logic ch, input logic dv, input logic wr, input logic tf,
                            input logic fst, input bit mid_we, input logic [31:0] mid_w,
                            output int s, output int a, output int r, output int other_low,
                            output int busy_ok);
      int stage;
      @(negedge clk);
      req_chan = ch; req_dev = dv; req_write = wr; req_taskfile = tf; req_first = fst;
      req_valid = 1'b1;
      @(posedge clk);
      s = 0; a = 0; r = 0; other_low = 0; busy_ok = 1; stage = 0;
      for (int k = 1; k < 200; k++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (mid_we && k == 1) begin
            cfg_we = 1'b1; cfg_chan = ch; cfg_dev = dv; cfg_wdata = mid_w;
         end
         if (mid_we && k == 2) cfg_we = 1'b0;
         if (done) begin
            if (!req_ready) busy_ok = 0;
            break;
         end
         if (req_ready) busy_ok = 0;
         if ((wr ? rd_n : wr_n) == 1'b0) other_low++;
         if ((wr ? wr_n : rd_n) == 1'b0) begin
            a++; stage = 1;
         end else if (stage == 0) s++;
         else r++;
      end
      cfg_we = 1'b0;
   endtask

   task automatic check_cycle(input logic ch, input logic dv, input logic wr, input logic tf,
                              input logic fst, input logic [31:0] w, input bit mid_we,
                              input logic [31:0] mid_w);
      int es, ea, er, s, a, r, ol, bz;
      expect_time(w, tf, fst, es, ea, er);
      run_cycle(ch, dv, wr, tf, fst, mid_we, mid_w, s, a, r, ol, bz);
      chk(s == es, tf ? "R5 task-file setup" : "R4 data setup", s, es);
      chk(a == ea, tf ? "R3 task-file active" : "R1 data active", a, ea);
      chk(r == er, tf ? "R3 task-file recovery" : "R2 data recovery", r, er);
      chk(ol == 0, "R7 other strobe stays high", ol, 0);
      chk(bz == 1, "R8 ready low while busy, done in idle clock", bz, 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [39:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      chk(rd_n == 1'b1 && wr_n == 1'b1, "R11 strobes high after reset", {rd_n, wr_n}, 3);
      chk(done == 1'b0, "R11 done low after reset", done, 0);
      chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
      for (int i = 0; i < 4; i++) begin
         req_chan = i[1]; req_dev = i[0];
         #1;
         chk(mode_flags == 4'h0, "R11 words cleared (flags)", mode_flags, 0);
      end
      // R11 cleared word gives 1-clock active and recovery, no setup
      check_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0);

      // table walk
      for (int i = 0; i < 8; i++) begin
         v = VEC[i];
         write_word(v[39], v[38], v[31:0]);
         req_chan = v[39]; req_dev = v[38];
         #1;
         chk(mode_flags == v[31:28], "R10 flags follow addressed word", mode_flags, v[31:28]);
         check_cycle(v[39], v[38], v[37], v[36], v[35], v[31:0], 1'b0, 32'h0);
      end

      // R10: same timing, different flag bits, same result
      write_word(1'b0, 1'b0, 32'hF0000053);
      check_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000053, 1'b0, 32'h0);

      // R6: distinct words at neighbouring indices stay separate
      write_word(1'b1, 1'b0, 32'h00000031);
      write_word(1'b0, 1'b1, 32'h00C001F2);
      check_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000031, 1'b0, 32'h0);
      check_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00C001F2, 1'b0, 32'h0);
      req_chan = 1'b1; req_dev = 1'b0; #1;
      chk(mode_flags == 4'h0, "R6 index 2 flags untouched", mode_flags, 0);

      // R9: rewrite mid-cycle, current uses old, next uses new
      write_word(1'b1, 1'b1, 32'h01400042);
      check_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h01400042, 1'b1, 32'h00000F0A);
      check_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000F0A, 1'b0, 32'h0);

      // R4: first flag clear ignores a full setup field
      write_word(1'b0, 1'b0, 32'h0FC00011);
      check_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0FC00011, 1'b0, 32'h0);
      check_cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0FC00011, 1'b0, 32'h0);

      // R11: reset mid-cycle clears words
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(rd_n && wr_n && !done && req_ready, "R11 idle after reset", {rd_n, wr_n, done, req_ready}, 4'b1101);
      req_chan = 1'b1; req_dev = 1'b1; #1;
      chk(mode_flags == 4'h0, "R11 word cleared by reset", mode_flags, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule